// File: doc/BRIEF.md
# Front-Panel Status Reporter and Command Acknowledger

This block plays the panel end of a byte link between a main controller and a front panel. The controller raises `en` to wake the panel. After a fixed wake-up delay, counted in ticks of a slow timebase, the panel starts sending a status report at a fixed period. Each report is two bytes, a lead byte and a tail byte. The controller sends two-byte commands over a separate receive stream. The panel answers every completed command with a single acknowledge byte.

Reports and acknowledges share one transmit stream with valid/ready flow control. A report is never split: an acknowledge that becomes due while a report is under way goes out after the report's last byte. One configuration command tells the panel that setup is complete. From then on each report is the lead byte alone. Dropping `en` returns everything to the idle, unconfigured state.

Top module: `panel_link_responder`

## Requirements
- R1: While `rst` is high, or on the cycle after `en` is sampled low, `tx_valid` and `rx_ready` are 0. Otherwise `rx_ready` is 1 one cycle after `en` is sampled high.
- R2: After `en` rises, the lead byte 0x80 of the first report appears on `tx_data` two clock cycles after the edge that samples the WAKE_TICKS-th `tick` pulse counted since enable.
- R3: Each later report's lead byte falls due every PERIOD_TICKS `tick` pulses. With `tx_ready` held high, its lead byte appears two cycles after the edge that samples the due tick.
- R4: Until configuration, a report is 0x80 followed directly by 0x40. The 0x40 is presented in the cycle after the 0x80 is taken.
- R5: Each second byte accepted on the receive stream completes a command. Two cycles later an acknowledge byte 0x20 is presented, if the transmit path is free. Up to ACK_DEPTH acknowledges can wait.
- R6: An acknowledge never sits between the two bytes of a report. If one is due during a report, it is presented after the report's tail byte is taken.
- R7: A command with first byte 0x0E and second byte 0xFC switches later reports to the single byte 0x80. A report whose lead byte was already presented keeps the format it started with.
- R8: Received bytes pair strictly in arrival order. A first byte still waiting for its partner when `en` falls is discarded.
- R9: Dropping `en` clears any byte in flight and any pending report or acknowledge. It restores the two-byte report format and restarts the wake-up delay for the next enable.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values.
- R11: When the transmit path frees with both a report and an acknowledge pending, the report goes first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Panel enable from the controller |
| tick | input | 1 | One-cycle timebase pulse |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte from controller |
| rx_ready | output | 1 | Receive byte accepted when high with `rx_valid` |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte to controller |
| tx_ready | input | 1 | Controller takes the transmit byte |

## Verification
The bench builds the block with WAKE_TICKS = 5 and PERIOD_TICKS = 6 and pulses `tick` on every fourth clock. A report period is then 24 clocks and the wake-up delay 20. At that scale, stalls longer than a full period fit into a short run. Such a stall queues a report and an acknowledge behind a held byte, which exercises the ordering rule. The run also covers the two-to-one report change and an enable drop with a half-received command. ACK_DEPTH stays at 4, deeper than any burst the bench sends.

// File: rtl/panel_link_pkg.sv
package panel_link_pkg;

  // Content of the byte currently presented on the transmit stream
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,  // nothing presented
    SLOT_LEAD = 2'd1,  // lead byte of a two-byte report, tail follows
    SLOT_LAST = 2'd2,  // final byte of a report
    SLOT_ACK  = 2'd3   // acknowledge byte
  } tx_slot_e;

  localparam logic [7:0] LEAD_BYTE_DEF = 8'h80;
  localparam logic [7:0] TAIL_BYTE_DEF = 8'h40;
  localparam logic [7:0] ACK_BYTE_DEF  = 8'h20;
  localparam logic [7:0] CFG_FIRST_DEF = 8'h0E;
  localparam logic [7:0] CFG_SECOND_DEF = 8'hFC;

endpackage

// File: rtl/panel_beat_timer.sv
module panel_beat_timer #(
  parameter int WAKE_TICKS   = 150,
  parameter int PERIOD_TICKS = 92
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  output logic due
);
  localparam int MAXC = (WAKE_TICKS > PERIOD_TICKS) ? WAKE_TICKS : PERIOD_TICKS;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WAKE_LAST   = CW'(WAKE_TICKS - 1);
  localparam logic [CW-1:0] PERIOD_LAST = CW'(PERIOD_TICKS - 1);

  logic          awake;
  logic [CW-1:0] cnt;
  logic          limit_hit;

  assign limit_hit = awake ? (cnt == PERIOD_LAST) : (cnt == WAKE_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      awake <= 1'b0;
      cnt   <= '0;
      due   <= 1'b0;
    end else begin
      due <= 1'b0;
      if (tick) begin
        if (limit_hit) begin
          due   <= 1'b1;
          cnt   <= '0;
          awake <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/panel_cmd_pairer.sv
module panel_cmd_pairer #(
  parameter logic [7:0] CFG_FIRST  = 8'h0E,
  parameter logic [7:0] CFG_SECOND = 8'hFC
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       cmd_done,
  output logic       short_fmt
);
  logic       have_first;
  logic [7:0] first_byte;
  logic       accept;

  assign accept = rx_valid && rx_ready;

  always_ff @(posedge clk) begin
    rx_ready <= en && !rst;
    if (rst || !en) begin
      have_first <= 1'b0;
      first_byte <= '0;
      cmd_done   <= 1'b0;
      short_fmt  <= 1'b0;
    end else begin
      cmd_done <= 1'b0;
      if (accept) begin
        if (!have_first) begin
          first_byte <= rx_data;
          have_first <= 1'b1;
        end else begin
          have_first <= 1'b0;
          cmd_done   <= 1'b1;
          if (first_byte == CFG_FIRST && rx_data == CFG_SECOND)
            short_fmt <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/panel_tx_sched.sv
module panel_tx_sched
  import panel_link_pkg::*;
#(
  parameter int         ACK_DEPTH = 4,
  parameter logic [7:0] LEAD_BYTE = 8'h80,
  parameter logic [7:0] TAIL_BYTE = 8'h40,
  parameter logic [7:0] ACK_BYTE  = 8'h20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       due,
  input  logic       cmd_done,
  input  logic       short_fmt,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       in_long
);
  localparam int AW = $clog2(ACK_DEPTH + 1);
  localparam logic [AW-1:0] ACK_CAP = AW'(ACK_DEPTH);

  tx_slot_e      slot;
  logic          rpt_pend;
  logic [AW-1:0] ack_cnt;
  logic [AW-1:0] ack_less;
  logic [AW-1:0] ack_next;
  logic          free, take_tail, take_rpt, take_ack;

  assign free      = !tx_valid || tx_ready;
  assign take_tail = free && (slot == SLOT_LEAD);
  assign take_rpt  = free && !take_tail && rpt_pend;
  assign take_ack  = free && !take_tail && !rpt_pend && (ack_cnt != '0);
  assign in_long   = (slot == SLOT_LEAD);

  always_comb begin
    ack_less = ack_cnt - AW'(take_ack);
    ack_next = ack_less;
    if (cmd_done && ack_less < ACK_CAP)
      ack_next = ack_less + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      slot     <= SLOT_IDLE;
      rpt_pend <= 1'b0;
      ack_cnt  <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      rpt_pend <= (rpt_pend && !take_rpt) || due;
      ack_cnt  <= ack_next;
      if (free) begin
        if (take_tail) begin
          tx_data  <= TAIL_BYTE;
          tx_valid <= 1'b1;
          slot     <= SLOT_LAST;
        end else if (take_rpt) begin
          tx_data  <= LEAD_BYTE;
          tx_valid <= 1'b1;
          slot     <= short_fmt ? SLOT_LAST : SLOT_LEAD;
        end else if (take_ack) begin
          tx_data  <= ACK_BYTE;
          tx_valid <= 1'b1;
          slot     <= SLOT_ACK;
        end else begin
          tx_valid <= 1'b0;
          slot     <= SLOT_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/panel_link_responder.sv
module panel_link_responder
  import panel_link_pkg::*;
#(
  parameter int         WAKE_TICKS   = 150,
  parameter int         PERIOD_TICKS = 92,
  parameter int         ACK_DEPTH    = 4,
  parameter logic [7:0] LEAD_BYTE    = LEAD_BYTE_DEF,
  parameter logic [7:0] TAIL_BYTE    = TAIL_BYTE_DEF,
  parameter logic [7:0] ACK_BYTE     = ACK_BYTE_DEF,
  parameter logic [7:0] CFG_FIRST    = CFG_FIRST_DEF,
  parameter logic [7:0] CFG_SECOND   = CFG_SECOND_DEF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready
);
  logic due;
  logic cmd_done;
  logic short_fmt;
  logic in_long;

  panel_beat_timer #(
    .WAKE_TICKS  (WAKE_TICKS),
    .PERIOD_TICKS(PERIOD_TICKS)
  ) u_timer (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .tick(tick),
    .due (due)
  );

  panel_cmd_pairer #(
    .CFG_FIRST (CFG_FIRST),
    .CFG_SECOND(CFG_SECOND)
  ) u_pairer (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_ready (rx_ready),
    .cmd_done (cmd_done),
    .short_fmt(short_fmt)
  );

  panel_tx_sched #(
    .ACK_DEPTH(ACK_DEPTH),
    .LEAD_BYTE(LEAD_BYTE),
    .TAIL_BYTE(TAIL_BYTE),
    .ACK_BYTE (ACK_BYTE)
  ) u_sched (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .due      (due),
    .cmd_done (cmd_done),
    .short_fmt(short_fmt),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .in_long  (in_long)
  );
endmodule

// File: rtl/panel_link_responder_chk.sv
module panel_link_responder_chk #(
  parameter logic [7:0] LEAD_BYTE = 8'h80,
  parameter logic [7:0] TAIL_BYTE = 8'h40
) (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       rx_ready,
  input logic       cmd_done,
  input logic       short_fmt,
  input logic       in_long
);
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!tx_valid && !rx_ready));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (en && tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_tail_follows_r6: assert property (@(posedge clk) disable iff (rst)
    (en && tx_valid && tx_ready && in_long) |=> (tx_valid && tx_data == TAIL_BYTE));

  p_lead_shown_r4: assert property (@(posedge clk) disable iff (rst)
    in_long |-> (tx_valid && tx_data == LEAD_BYTE));

  p_cfg_on_cmd_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(short_fmt) |-> cmd_done);
endmodule

bind panel_link_responder panel_link_responder_chk #(
  .LEAD_BYTE(LEAD_BYTE),
  .TAIL_BYTE(TAIL_BYTE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .rx_ready (rx_ready),
  .cmd_done (cmd_done),
  .short_fmt(short_fmt),
  .in_long  (in_long)
);

// File: tb/panel_link_responder_tb_top.sv
`timescale 1ns/1ps
module panel_link_responder_tb_top;
  localparam int WAKE   = 5;
  localparam int PERIOD = 6;
  localparam int TDIV   = 4;
  localparam int ACKD   = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       tick = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_ready;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b1;

  always #2 clk = ~clk;

  panel_link_responder #(
    .WAKE_TICKS  (WAKE),
    .PERIOD_TICKS(PERIOD),
    .ACK_DEPTH   (ACKD)
  ) dut_i (
    .clk(clk), .rst(rst), .en(en), .tick(tick),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit ended = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // timebase pulse every TDIV clocks
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TDIV;
    tick = (tdiv == TDIV - 1);
  end

  // monitor of taken transmit bytes
  logic [7:0] taken_q[$];
  int         taken_cyc[$];
  always @(posedge clk) begin
    cyc++;
    if (tx_valid && tx_ready && !rst) begin
      taken_q.push_back(tx_data);
      taken_cyc.push_back(cyc);
    end
    if (cyc > 100000 && !ended) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
      finish_run();
    end
  end

  // behavioural reference model
  int         m_left = WAKE;
  bit         m_due = 0, m_pend = 0, m_done = 0, m_rdy = 0;
  int         m_acks = 0;
  bit         m_half_ok = 0, m_short = 0, m_first = 1;
  logic [7:0] m_half = 8'h00;
  bit         m_valid = 0;
  logic [7:0] m_data = 8'h00;
  int         m_kind = 0;  // 0 none, 1 lead of long, 2 last of report, 3 ack
  string      m_tag = "R1";

  always @(posedge clk) begin
    bit free, g_tail, g_rpt, g_ack, n_due, n_done;
    int n_acks;
    if (rst || !en) begin
      m_left = WAKE; m_due = 0; m_pend = 0; m_acks = 0; m_done = 0;
      m_half_ok = 0; m_short = 0; m_valid = 0; m_kind = 0; m_first = 1;
      m_tag = rst ? "R1" : "R9";
    end else begin
      free   = !m_valid || tx_ready;
      g_tail = free && m_kind == 1;
      g_rpt  = free && !g_tail && m_pend;
      g_ack  = free && !g_tail && !m_pend && m_acks > 0;
      if (free) begin
        if (g_tail) begin
          m_valid = 1; m_data = 8'h40; m_kind = 2; m_tag = "R4";
        end else if (g_rpt) begin
          m_valid = 1; m_data = 8'h80; m_kind = m_short ? 2 : 1;
          if (m_first) m_tag = "R2";
          else if (m_acks > 0) m_tag = "R11";
          else if (m_short) m_tag = "R7";
          else m_tag = "R3";
          m_first = 0;
        end else if (g_ack) begin
          m_valid = 1; m_data = 8'h20; m_kind = 3; m_tag = "R5";
        end else begin
          m_valid = 0; m_kind = 0; m_tag = "R6";
        end
      end else m_tag = "R10";
      m_pend = (m_pend && !g_rpt) || m_due;
      n_acks = m_acks - (g_ack ? 1 : 0);
      if (m_done && n_acks < ACKD) n_acks++;
      m_acks = n_acks;
      n_due = 0;
      if (tick) begin
        m_left--;
        if (m_left == 0) begin n_due = 1; m_left = PERIOD; end
      end
      m_due = n_due;
      n_done = 0;
      if (rx_valid && m_rdy) begin
        if (!m_half_ok) begin m_half = rx_data; m_half_ok = 1; end
        else begin
          m_half_ok = 0; n_done = 1;
          if (m_half == 8'h0E && rx_data == 8'hFC) m_short = 1;
        end
      end
      m_done = n_done;
    end
    m_rdy = !rst && en;
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!ended && cyc > 0) begin
      check(tx_valid === m_valid, m_tag, int'(tx_valid), int'(m_valid));
      if (m_valid) check(tx_data === m_data, m_tag, int'(tx_data), int'(m_data));
      check(rx_ready === m_rdy, "R1", int'(rx_ready), int'(m_rdy));
    end
  end

  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_data  = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_lead();
    int n = 0;
    while (!(tx_valid && tx_data == 8'h80) && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic int count_from(input int idx, input logic [7:0] b);
    int c = 0;
    for (int i = idx; i < taken_q.size(); i++) if (taken_q[i] == b) c++;
    return c;
  endfunction

  initial begin
    int idx, s0, s1, n80;
    int starts[$];
    @(negedge clk);
    idle(4);
    // R1: reset state
    check(tx_valid == 0, "R1", int'(tx_valid), 0);
    check(rx_ready == 0, "R1", int'(rx_ready), 0);
    rst = 1'b0;
    idle(10);
    check(tx_valid == 0, "R1", int'(tx_valid), 0);

    // wake up, long reports
    idx = taken_q.size();
    en = 1'b1;
    idle(100);
    n80 = count_from(idx, 8'h80);
    check(n80 >= 3, "R2", n80, 3);
    check(count_from(idx, 8'h40) == n80, "R4", count_from(idx, 8'h40), n80);
    for (int i = idx; i < taken_q.size(); i++)
      if (taken_q[i] == 8'h80) starts.push_back(taken_cyc[i]);
    s0 = starts[1]; s1 = starts[2];
    check(s1 - s0 == PERIOD * TDIV, "R3", s1 - s0, PERIOD * TDIV);

    // acknowledge while a long report is held
    wait_lead();
    tx_ready = 1'b0;
    idx = taken_q.size();
    send_byte(8'h01);
    send_byte(8'h02);
    idle(4);
    tx_ready = 1'b1;
    idle(6);
    check(taken_q[idx] == 8'h80, "R6", int'(taken_q[idx]), 8'h80);
    check(taken_q[idx+1] == 8'h40, "R6", int'(taken_q[idx+1]), 8'h40);
    check(taken_q[idx+2] == 8'h20, "R5", int'(taken_q[idx+2]), 8'h20);

    // configuration
    send_byte(8'h0D); send_byte(8'h3F);
    send_byte(8'h0E); send_byte(8'hFC);
    idle(10);
    idx = taken_q.size();
    idle(80);
    check(count_from(idx, 8'h40) == 0, "R7", count_from(idx, 8'h40), 0);
    check(count_from(idx, 8'h80) >= 3, "R7", count_from(idx, 8'h80), 3);

    // long stall: report and ack both pend
    wait_lead();
    tx_ready = 1'b0;
    idx = taken_q.size();
    send_byte(8'h04); send_byte(8'h74);
    idle(14);
    check(tx_valid == 1 && tx_data == 8'h80, "R10", int'(tx_data), 8'h80);
    idle(16);
    tx_ready = 1'b1;
    idle(6);
    check(taken_q[idx] == 8'h80, "R11", int'(taken_q[idx]), 8'h80);
    check(taken_q[idx+1] == 8'h80, "R11", int'(taken_q[idx+1]), 8'h80);
    check(taken_q[idx+2] == 8'h20, "R11", int'(taken_q[idx+2]), 8'h20);

    // odd byte then enable drop
    idle(3);
    send_byte(8'h0E);
    en = 1'b0;
    idle(3);
    check(tx_valid == 0, "R9", int'(tx_valid), 0);
    check(rx_ready == 0, "R9", int'(rx_ready), 0);
    idx = taken_q.size();
    en = 1'b1;
    idle(2);
    send_byte(8'hFC);
    send_byte(8'h55);
    idle(70);
    check(count_from(idx, 8'h20) == 1, "R8", count_from(idx, 8'h20), 1);
    check(count_from(idx, 8'h40) >= 1, "R9", count_from(idx, 8'h40), 1);
    check(count_from(idx, 8'h40) == count_from(idx, 8'h80), "R8",
          count_from(idx, 8'h40), count_from(idx, 8'h80));

    finish_run();
  end
endmodule